// File: doc/BRIEF.md
# RTC Power-On Reset Sequencer

This block brings an external real-time-clock device to a known state after power-up. It runs a fixed series of accesses over a simple register bus. First it waits until the device may be accessed, then it makes one throw-away read. Next it samples the device's low-voltage flag, which it clears in fast mode. It then writes the reset script and waits for the device's internal reset to finish before it reports completion. The sequence starts by itself when `rst_n` is released. A `start` pulse runs it again once the previous run has finished.

Two start-up paths exist, selected by `fast_mode` and sampled when a run begins. The normal path waits out the full power-up window before the first access. The fast path begins accessing at once. It keeps clearing and re-reading the flag until the flag reads 0 or the power-up window has elapsed. All waits are counted in 1 ms ticks from a prescaler on the system clock. Each wait is lengthened by one tick for margin.

The register bus is a request/acknowledge handshake, the valid/ready pair of this block. `bus_req` acts as valid and `bus_ack` as ready. The slave may apply back-pressure by holding `bus_ack` low for any number of cycles. While it does, the sequencer keeps `bus_req` and every command field steady. The transfer completes on the first rising clock edge at which both are high. `bus_rdata` is sampled at that same edge, and the sequencer drops `bus_req` on that edge.

Top module: `rtc_init_seq`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `done` and `vlf_seen` are 0 and `busy` is 1, meaning a run is pending.
- R2: In normal mode no request is raised until POWERUP_MS+1 ticks (41 ms by default) after reset release or an accepted start.
- R3: The first access of every run is a read of bank 0, address 0h. Its returned data is discarded and never affects `vlf_seen`.
- R4: The second access reads the flag register (bank 0, address Eh), and the flag is bit 1 of the data. `vlf_seen` becomes 1 if that read returns the flag set. It stays 1 until the next accepted start or reset.
- R5: In normal mode the flag is read exactly once and never written, whatever its value.
- R6: In fast mode the first request is raised without the power-up wait. While a flag read returns 1, the block writes the read byte back with bit 1 cleared to the flag register, then reads the flag register again. A flag read of 0 ends the loop.
- R7: In fast mode, a flag read that returns 1 after POWERUP_MS+1 ticks have elapsed since the run began ends the loop without another clear. The write script follows.
- R8: The script is six writes in this order: bank 3 addr 2h←00h, bank 3 addr Fh←80h, then bank 5 addr 0h←6Ch, 1h←03h, 2h←10h, 3h←20h. It runs whether the flag was found set or clear, and no other access follows it.
- R9: Bank 3 address Fh is written with bit 7 set exactly once per run, as the second script write.
- R10: A request holds `bus_req` and its fields stable until acknowledged. It drops `bus_req` on the acknowledging edge, and at least one idle cycle separates two requests.
- R11: After the last script write is acknowledged, no request is made for RESET_MS+1 ticks (3 ms by default). Then `done` rises.
- R12: When `done` is 1, `busy` is 0 and a `start` pulse re-runs the whole sequence from the power-up wait. The pulse clears `done` and `vlf_seen`. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release begins a run |
| start | input | 1 | Re-run request, accepted only when idle |
| fast_mode | input | 1 | 1 selects flag polling instead of the fixed power-up wait |
| bus_req | output | 1 | Request valid |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_bank | output | 3 | Register bank |
| bus_addr | output | 4 | Register address within the bank |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled with the acknowledge |
| bus_ack | input | 1 | Acknowledge (ready) from the device side |
| busy | output | 1 | A run is pending or in progress |
| done | output | 1 | The last run completed |
| vlf_seen | output | 1 | The low-voltage flag read as 1 during this run |

## Verification
Runs in normal mode with the flag set and clear separate a block that waits out the power-up window from one that starts early. They also show whether a set flag wrongly triggers clearing. Fast-mode runs in which the flag clears after one, two or three writes confirm that the poll loop ends on the first 0 read. A fast run in which the flag never clears shows that the timeout ends polling and that the script still runs after it. Random acknowledge latency, a start pulse during a run, and a dummy read that always returns the flag bit set expose handshake slips, restarts that should not happen, and dummy data leaking into the flag record.

// File: rtl/rtc_init_pkg.sv
package rtc_init_pkg;
  localparam int BANK_W     = 3;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int SCRIPT_LEN = 6;
  localparam int STEP_W     = $clog2(SCRIPT_LEN);

  // test/reset control location; only script step 1 may set its top bit
  localparam logic [BANK_W-1:0] TEST_BANK = 3'd3;
  localparam logic [ADDR_W-1:0] TEST_ADDR = 4'hF;
  localparam int                TEST_BIT  = 7;
  localparam logic [BANK_W-1:0] CFG_BANK  = 3'd5;

  typedef enum logic [3:0] {
    ST_PWR_WAIT,
    ST_DUMMY_GO,
    ST_DUMMY_WT,
    ST_FLAG_GO,
    ST_FLAG_WT,
    ST_CLR_GO,
    ST_CLR_WT,
    ST_SCR_GO,
    ST_SCR_WT,
    ST_RST_WAIT,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } reg_access_t;

  // reset script; the order is part of the behaviour
  function automatic reg_access_t script_step(input logic [STEP_W-1:0] idx);
    reg_access_t s;
    case (idx)
      3'd0:    s = '{bank: TEST_BANK, addr: 4'h2, data: 8'h00};
      3'd1:    s = '{bank: TEST_BANK, addr: TEST_ADDR, data: 8'h80};
      3'd2:    s = '{bank: CFG_BANK, addr: 4'h0, data: 8'h6C};
      3'd3:    s = '{bank: CFG_BANK, addr: 4'h1, data: 8'h03};
      3'd4:    s = '{bank: CFG_BANK, addr: 4'h2, data: 8'h10};
      default: s = '{bank: CFG_BANK, addr: 4'h3, data: 8'h20};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rtc_ms_tick.sv
module rtc_ms_tick #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr || cnt == LAST)   cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clr;

  generate
    if (DIV > 1) begin : g_spacing_chk
      // ticks are never back to back, so a wait cannot collapse
      p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int MAX_TICKS = 41,
  localparam int W = $clog2(MAX_TICKS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(MAX_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (tick && count != TOP) count <= count + 1'b1;
  end

  p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(count));
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP);
endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
  import rtc_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_we,
  input  logic [BANK_W-1:0] go_bank,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BANK_W-1:0] bus_bank,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_bank  <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      xfer_done <= 1'b0;
      rdata_q   <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req   <= 1'b0;
          xfer_done <= 1'b1;
          rdata_q   <= bus_rdata;
        end
      end else if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_bank  <= go_bank;
        bus_addr  <= go_addr;
        bus_wdata <= go_wdata;
      end
    end
  end

  p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_bank)
                               && $stable(bus_addr) && $stable(bus_wdata)));
  p_drop_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);
  p_idle_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |=> !bus_req);
  p_go_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!bus_req && !xfer_done));
endmodule

// File: rtl/rtc_init_seq.sv
module rtc_init_seq
  import rtc_init_pkg::*;
#(
  parameter int                CLK_HZ     = 50_000_000,
  parameter int                POWERUP_MS = 40,
  parameter int                RESET_MS   = 2,
  parameter logic [BANK_W-1:0] FLAG_BANK  = 3'd0,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 4'hE,
  parameter int                FLAG_BIT   = 1,
  parameter logic [BANK_W-1:0] DUMMY_BANK = 3'd0,
  parameter logic [ADDR_W-1:0] DUMMY_ADDR = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fast_mode,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BANK_W-1:0] bus_bank,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              busy,
  output logic              done,
  output logic              vlf_seen
);
  localparam int TICK_DIV  = CLK_HZ / 1000;
  localparam int PWR_TICKS = POWERUP_MS + 1;
  localparam int RST_TICKS = RESET_MS + 1;
  localparam int TMAX      = (PWR_TICKS > RST_TICKS) ? PWR_TICKS : RST_TICKS;
  localparam int TW        = $clog2(TMAX + 1);
  localparam logic [TW-1:0]     PWR_T     = TW'(PWR_TICKS);
  localparam logic [TW-1:0]     RST_T     = TW'(RST_TICKS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SCRIPT_LEN - 1);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

  seq_state_e        st, nxt;
  logic [STEP_W-1:0] step;
  logic              fast_q;
  logic              clr_tmr, tick, restart, step_inc;
  logic [TW-1:0]     elapsed;
  logic              go, go_we;
  logic [BANK_W-1:0] go_bank;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_wdata;
  logic              xfer_done;
  logic [DATA_W-1:0] rdata_q;
  logic              flag_one;
  reg_access_t       cur;

  rtc_ms_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr_tmr), .tick(tick)
  );

  rtc_tick_timer #(.MAX_TICKS(TMAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr_tmr), .tick(tick), .count(elapsed)
  );

  rtc_bus_port u_port (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_we(go_we), .go_bank(go_bank), .go_addr(go_addr), .go_wdata(go_wdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_bank(bus_bank), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .rdata_q(rdata_q)
  );

  assign cur      = script_step(step);
  assign flag_one = rdata_q[FLAG_BIT];
  assign restart  = (st == ST_DONE) && start;

  always_comb begin
    nxt      = st;
    go       = 1'b0;
    go_we    = 1'b0;
    go_bank  = DUMMY_BANK;
    go_addr  = DUMMY_ADDR;
    go_wdata = '0;
    clr_tmr  = 1'b0;
    step_inc = 1'b0;
    case (st)
      ST_PWR_WAIT: if (fast_q || elapsed >= PWR_T) nxt = ST_DUMMY_GO;
      ST_DUMMY_GO: begin go = 1'b1; nxt = ST_DUMMY_WT; end
      ST_DUMMY_WT: if (xfer_done) nxt = ST_FLAG_GO;
      ST_FLAG_GO: begin
        go = 1'b1; go_bank = FLAG_BANK; go_addr = FLAG_ADDR; nxt = ST_FLAG_WT;
      end
      ST_FLAG_WT: if (xfer_done) begin
        if (flag_one && fast_q && elapsed < PWR_T) nxt = ST_CLR_GO;
        else                                       nxt = ST_SCR_GO;
      end
      ST_CLR_GO: begin
        go = 1'b1; go_we = 1'b1; go_bank = FLAG_BANK; go_addr = FLAG_ADDR;
        go_wdata = rdata_q & ~FLAG_MASK;
        nxt = ST_CLR_WT;
      end
      ST_CLR_WT: if (xfer_done) nxt = ST_FLAG_GO;
      ST_SCR_GO: begin
        go = 1'b1; go_we = 1'b1; go_bank = cur.bank; go_addr = cur.addr;
        go_wdata = cur.data;
        nxt = ST_SCR_WT;
      end
      ST_SCR_WT: if (xfer_done) begin
        if (step == LAST_STEP) begin nxt = ST_RST_WAIT; clr_tmr = 1'b1; end
        else begin nxt = ST_SCR_GO; step_inc = 1'b1; end
      end
      ST_RST_WAIT: if (elapsed >= RST_T) nxt = ST_DONE;
      ST_DONE: if (start) begin nxt = ST_PWR_WAIT; clr_tmr = 1'b1; end
      default: nxt = ST_PWR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_PWR_WAIT;
      step     <= '0;
      vlf_seen <= 1'b0;
    end else begin
      st <= nxt;
      if (restart)       step <= '0;
      else if (step_inc) step <= step + 1'b1;
      if (restart)                                       vlf_seen <= 1'b0;
      else if (st == ST_FLAG_WT && xfer_done && flag_one) vlf_seen <= 1'b1;
    end
  end

  // mode is captured while in reset and on an accepted restart
  always_ff @(posedge clk) begin
    if (!rst_n || restart) fast_q <= fast_mode;
  end

  assign done = (st == ST_DONE);
  assign busy = !done;

  p_no_early_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !fast_q) |-> elapsed >= PWR_T);
  p_dummy_is_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && st == ST_DUMMY_WT) |-> (!bus_we && bus_bank == DUMMY_BANK && bus_addr == DUMMY_ADDR));
  p_seen_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vlf_seen && !restart) |=> vlf_seen);
  p_flag_write_fast_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_bank == FLAG_BANK && bus_addr == FLAG_ADDR)
      |-> (fast_q && !bus_wdata[FLAG_BIT]));
  p_testbit_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_bank == TEST_BANK && bus_addr == TEST_ADDR && bus_wdata[TEST_BIT])
      |-> step == STEP_W'(1));
  p_quiet_settle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RST_WAIT) |-> !bus_req);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  p_restart_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!vlf_seen && !done));
endmodule

// File: tb/rtc_init_seq_tb_top.sv
`timescale 1ns/1ps
module rtc_init_seq_tb_top;
  localparam int CLK_HZ = 20000;
  localparam int D      = CLK_HZ / 1000;
  localparam int PWR    = 41;
  localparam int RST    = 3;
  localparam int LOGN   = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, start = 1'b0, fast_mode = 1'b0, bus_ack = 1'b0;
  logic [7:0] bus_rdata = 8'h00;
  logic       bus_req, bus_we, busy, done, vlf_seen;
  logic [2:0] bus_bank;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;

  always #2.5 clk = ~clk;

  rtc_init_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fast_mode(fast_mode),
    .bus_req(bus_req), .bus_we(bus_we), .bus_bank(bus_bank), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .done(done), .vlf_seen(vlf_seen)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit vlf_dev;
  int k_left, lat = 0, n_log = 0, hs_err = 0, first_req_cyc = 0;
  bit req_seen = 0, pend = 0;
  logic [15:0] snap;
  logic       lg_we   [LOGN];
  logic [2:0] lg_bank [LOGN];
  logic [3:0] lg_addr [LOGN];
  logic [7:0] lg_wdata[LOGN];
  logic [7:0] lg_rdata[LOGN];
  int         lg_cyc  [LOGN];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_step(input int i);
    case (i)
      0: return {3'd3, 4'h2, 8'h00};
      1: return {3'd3, 4'hF, 8'h80};
      2: return {3'd5, 4'h0, 8'h6C};
      3: return {3'd5, 4'h1, 8'h03};
      4: return {3'd5, 4'h2, 8'h10};
      default: return {3'd5, 4'h3, 8'h20};
    endcase
  endfunction

  function automatic bit is_flag(input logic [2:0] b, input logic [3:0] a);
    return (b == 3'd0) && (a == 4'hE);
  endfunction

  // device-side responder with random acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bus_ack = 1'b0; pend = 0;
      end else if (bus_ack) begin
        bus_ack = 1'b0; pend = 0;
        if (bus_req) hs_err++;
      end else if (bus_req) begin
        if (!req_seen) begin req_seen = 1; first_req_cyc = cyc; end
        if (!pend) begin pend = 1; snap = {bus_we, bus_bank, bus_addr, bus_wdata}; end
        else if ({bus_we, bus_bank, bus_addr, bus_wdata} != snap) hs_err++;
        if (lat > 0) lat--;
        else begin
          if (!bus_we) begin
            if (is_flag(bus_bank, bus_addr))
              bus_rdata = (8'($urandom) & 8'hFD) | {6'd0, vlf_dev, 1'b0};
            else
              bus_rdata = 8'($urandom) | 8'h02;
          end else if (is_flag(bus_bank, bus_addr) && !bus_wdata[1]) begin
            if (k_left > 0) k_left--;
            if (k_left == 0) vlf_dev = 1'b0;
          end
          if (n_log < LOGN) begin
            lg_we[n_log] = bus_we; lg_bank[n_log] = bus_bank; lg_addr[n_log] = bus_addr;
            lg_wdata[n_log] = bus_wdata; lg_rdata[n_log] = bus_we ? 8'h00 : bus_rdata;
            lg_cyc[n_log] = cyc;
            n_log++;
          end
          bus_ack = 1'b1;
          lat = int'($urandom % 4);
        end
      end
    end
  end

  // k >= 1000 means the flag never clears (timeout case)
  task automatic run_case(input bit by_reset, input bit fast, input bit vlf, input int k,
                          input bit poke);
    int t0, p, nclr, expc, tb, limit, tcount;
    bit last1;
    @(negedge clk);
    vlf_dev = vlf; k_left = k; n_log = 0; req_seen = 0; hs_err = 0; fast_mode = fast;
    if (by_reset) begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({bus_req, done, vlf_seen, busy} == 4'b0001, "R1 reset state",
          {bus_req, done, vlf_seen, busy}, 4'b0001);
      rst_n = 1'b1;
      t0 = cyc;
    end else begin
      start = 1'b1;
      t0 = cyc + 1;
      @(negedge clk);
      start = 1'b0;
      chk(!done && !vlf_seen && busy, "R12 restart clears status",
          {done, vlf_seen, busy}, 3'b001);
    end
    limit = 0;
    while (!done && limit < 6000) begin
      @(negedge clk);
      limit++;
      start = poke && (limit == 300);
    end
    start = 1'b0;
    chk(done, "R11 run completes", done, 1);
    if (!done || n_log < 8) begin
      chk(0, "R8 access count", n_log, 8);
      return;
    end
    chk(!lg_we[0] && lg_bank[0] == 0 && lg_addr[0] == 0, "R3 dummy read first",
        {lg_we[0], lg_bank[0], lg_addr[0]}, 0);
    chk(!lg_we[1] && is_flag(lg_bank[1], lg_addr[1]), "R4 flag read second",
        {lg_we[1], lg_bank[1], lg_addr[1]}, 8'h0E);
    p = 2; nclr = 0; last1 = lg_rdata[1][1];
    while (p + 1 < n_log && lg_we[p] && is_flag(lg_bank[p], lg_addr[p])) begin
      chk(lg_wdata[p] == (lg_rdata[p-1] & 8'hFD), "R6 clear write data",
          lg_wdata[p], lg_rdata[p-1] & 8'hFD);
      chk(!lg_we[p+1] && is_flag(lg_bank[p+1], lg_addr[p+1]), "R6 read-back follows clear",
          {lg_we[p+1], lg_bank[p+1], lg_addr[p+1]}, 8'h0E);
      last1 = lg_rdata[p+1][1];
      nclr++;
      p += 2;
    end
    expc = (!fast || !vlf) ? 0 : ((k >= 1000) ? -1 : k);
    if (expc >= 0) begin
      if (fast) chk(nclr == expc, "R6 clear count", nclr, expc);
      else      chk(nclr == expc, "R5 no clearing in normal mode", nclr, expc);
    end else begin
      chk(nclr >= 1 && last1, "R7 polled until timeout", nclr, 1);
      tb = lg_cyc[p] - t0;
      chk(tb >= PWR * D && tb <= PWR * D + 40, "R7 timeout exit time", tb, PWR * D);
    end
    chk(n_log == p + 6, "R8 script length", n_log - p, 6);
    for (int i = 0; i < 6; i++) begin
      if (p + i < n_log)
        chk(lg_we[p+i] && {lg_bank[p+i], lg_addr[p+i], lg_wdata[p+i]} == exp_step(i),
            "R8 script entry", {lg_we[p+i], lg_bank[p+i], lg_addr[p+i], lg_wdata[p+i]},
            {1'b1, exp_step(i)});
    end
    tcount = 0;
    for (int i = 0; i < n_log; i++)
      if (lg_we[i] && lg_bank[i] == 3 && lg_addr[i] == 4'hF && lg_wdata[i][7]) tcount++;
    chk(tcount == 1, "R9 test bit set once", tcount, 1);
    chk(vlf_seen == vlf, "R4 flag record", vlf_seen, vlf);
    if (!vlf) chk(!vlf_seen, "R3 dummy data discarded", vlf_seen, 0);
    tb = first_req_cyc - t0;
    if (fast) chk(tb >= 1 && tb <= 3, "R6 no power-up wait", tb, 2);
    else      chk(tb >= PWR * D + 1 && tb <= PWR * D + 3, "R2 power-up wait", tb, PWR * D + 2);
    tb = cyc - lg_cyc[n_log-1];
    chk(tb >= RST * D + 2 && tb <= RST * D + 4, "R11 settle wait", tb, RST * D + 3);
    chk(hs_err == 0, "R10 handshake", hs_err, 0);
    chk(!busy && !bus_req, "R12 idle after done", {busy, bus_req}, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    run_case(1, 0, 1, 1000, 0);   // normal, flag set: read once, no clear
    run_case(0, 0, 0, 1, 1);      // normal, flag clear, start pulse while busy
    run_case(0, 1, 1, 2, 0);      // fast, clears after two writes
    run_case(0, 1, 0, 1, 0);      // fast, flag already clear
    run_case(0, 1, 1, 1000, 0);   // fast, flag stuck: timeout path
    run_case(1, 1, 1, 1, 0);      // fast from reset release
    for (int r = 0; r < 4; r++) begin
      bit f, v;
      int kk;
      f = 1'($urandom % 2);
      v = 1'($urandom % 2);
      kk = 1 + int'($urandom % 3);
      run_case(0, f, v, kk, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule